// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits in the decode stage next to the instruction decoder. For each decoded instruction it takes the current privilege mode, a one-hot instruction-class vector and a handful of trap-control bits from the machine and hypervisor status registers. From these it decides whether the instruction must trap as an illegal instruction, must trap as a virtual instruction, or is an environment call. An environment call also needs a cause code, and the block picks that code from the mode.

The verdict is registered and appears one cycle after the instruction is presented. The block does not look at instruction bits. It does not write any status register and it does not sequence the trap. The decoder supplies the class and the trap unit consumes the flags. When an instruction meets both an illegal condition and a virtual-instruction condition, it is reported only as illegal.

Privilege mode encoding on `mode_i`: 0 = machine (M), 1 = hypervisor-extended supervisor (HS), 2 = host user (HU), 3 = virtual supervisor (VS), 4 = virtual user (VU). The bit positions of the class one-hot `cls_i` are as follows: 0 = address-translation fence, 1 = partial fence, 2 = guest-physical fence, 3 = guest-virtual fence, 4 = hypervisor load/store, 5 = floating-point, 6 = floating-point using the dynamic rounding mode, 7 = vector, 8 = wait-for-interrupt, 9 = environment call. A value of 0 on `fs_i` or `vs_i` means the unit is Off.

Top module: `priv_legality_chk`

## Requirements
- R1: An address-translation fence (class bit 0) is flagged illegal in HS when `tvm_i`=1 and always in HU. It is flagged virtual in VS when `vtvm_i`=1 and always in VU. It is legal in M.
- R2: A partial fence (class bit 1) is illegal in HU and virtual in VU. It is legal in M, HS and VS.
- R3: A guest-physical fence (bit 2) has the same illegal condition as R1. A guest-virtual fence (bit 3) is illegal only in HU. Both are virtual in VS and VU.
- R4: A hypervisor load/store (bit 4) is illegal in HU when `hu_i`=0, and virtual in VS and VU.
- R5: A floating-point instruction (bit 5 or 6) is illegal when `fs_i`=0. A vector instruction (bit 7) is illegal when `vs_i`=0.
- R6: Wait-for-interrupt (bit 8) is illegal in HU, and in any mode other than M when `tw_i`=1.
- R7: Wait-for-interrupt is virtual in VU when `tw_i`=0, and in VS when `tw_i`=0 and `vtw_i`=1.
- R8: A dynamic-rounding floating-point instruction (bit 6) is illegal when `frm_i` exceeds 4.
- R9: An environment call (bit 9) raises `ecall_o` with `ecall_cause_o` = 3 in M, 1 in HS, 2 in VS, and 0 in HU or VU. It sets neither fault flag.
- R10: `illegal_o` and `virtual_o` are never high together. Illegal wins when both conditions hold.
- R11: Outputs follow a valid input by exactly one cycle. All outputs are zero the cycle after `valid_i` is low, and a synchronous reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A decoded instruction is present |
| mode_i | input | 3 | Current privilege mode (0 M, 1 HS, 2 HU, 3 VS, 4 VU) |
| cls_i | input | 10 | Instruction-class one-hot |
| tvm_i | input | 1 | Trap translation-management in HS |
| tw_i | input | 1 | Trap wait-for-interrupt outside M |
| vtvm_i | input | 1 | Trap translation-management in VS |
| vtw_i | input | 1 | Trap wait-for-interrupt in VS |
| hu_i | input | 1 | Allow hypervisor loads/stores from HU |
| fs_i | input | 2 | Floating-point unit state, 0 = Off |
| vs_i | input | 2 | Vector unit state, 0 = Off |
| frm_i | input | 3 | Dynamic rounding-mode field |
| illegal_o | output | 1 | Illegal-instruction verdict |
| virtual_o | output | 1 | Virtual-instruction verdict |
| ecall_o | output | 1 | Environment call seen |
| ecall_cause_o | output | 2 | Environment-call cause code |

## Verification
Some properties are checked by assertions on every cycle. The two fault flags are exclusive. Outputs stay quiet after an idle cycle. Nothing in M mode outside the floating-point and vector classes faults. No virtual fault comes from a host mode. A reserved rounding mode always yields illegal. An M-mode environment call carries cause 3. Other behaviour shows only in the bench's directed scenarios and its exhaustive sweep over mode, class and control bits against an independently written model. That covers the per-mode split between the two causes, the individual control bits of each class, the HU/VU sharing of the user call cause, and the behaviour of reset asserted in the middle of a stream.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_M  = 3'd0,
    PM_HS = 3'd1,
    PM_HU = 3'd2,
    PM_VS = 3'd3,
    PM_VU = 3'd4
  } pmode_e;

  // class one-hot bit positions (decoder contract)
  localparam int unsigned C_XLAT  = 0;
  localparam int unsigned C_PART  = 1;
  localparam int unsigned C_GPA   = 2;
  localparam int unsigned C_GVA   = 3;
  localparam int unsigned C_HLS   = 4;
  localparam int unsigned C_FP    = 5;
  localparam int unsigned C_FPDYN = 6;
  localparam int unsigned C_VEC   = 7;
  localparam int unsigned C_WFI   = 8;
  localparam int unsigned C_ECALL = 9;
  localparam int unsigned NCLS    = 10;

  localparam int unsigned N_HYP = 5;  // classes 0..4
  localparam int unsigned N_EXT = 4;  // classes 5..8
  localparam int unsigned EXT_BASE = C_FP;

  localparam int unsigned CAUSE_W = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_U  = 2'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_HS = 2'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_VS = 2'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_M  = 2'd3;

  typedef struct packed {
    logic ill;
    logic virt;
  } verdict_t;

  function automatic logic is_guest(logic [MODE_W-1:0] m);
    return (m == PM_VS) || (m == PM_VU);
  endfunction

  // hypervisor / fence class rules, k = class index
  function automatic verdict_t hyp_rule(int unsigned k, logic [MODE_W-1:0] m,
                                        logic tvm, logic vtvm, logic hu);
    verdict_t r;
    r = '0;
    case (k)
      C_XLAT: begin
        r.ill  = ((m == PM_HS) && tvm) || (m == PM_HU);
        r.virt = ((m == PM_VS) && vtvm) || (m == PM_VU);
      end
      C_PART: begin
        r.ill  = (m == PM_HU);
        r.virt = (m == PM_VU);
      end
      C_GPA: begin
        r.ill  = ((m == PM_HS) && tvm) || (m == PM_HU);
        r.virt = is_guest(m);
      end
      C_GVA: begin
        r.ill  = (m == PM_HU);
        r.virt = is_guest(m);
      end
      C_HLS: begin
        r.ill  = (m == PM_HU) && !hu;
        r.virt = is_guest(m);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic verdict_t wfi_rule(logic [MODE_W-1:0] m, logic tw, logic vtw);
    verdict_t r;
    r.ill  = (m == PM_HU) || ((m != PM_M) && tw);
    r.virt = !tw && ((m == PM_VU) || ((m == PM_VS) && vtw));
    return r;
  endfunction

  function automatic logic [CAUSE_W-1:0] ecall_cause(logic [MODE_W-1:0] m);
    logic [CAUSE_W-1:0] c;
    case (m)
      PM_M:    c = CAUSE_M;
      PM_HS:   c = CAUSE_HS;
      PM_VS:   c = CAUSE_VS;
      default: c = CAUSE_U;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/priv_hyp_rules.sv
module priv_hyp_rules
  import priv_chk_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              tvm,
  input  logic              vtvm,
  input  logic              hu,
  output logic [N_HYP-1:0]  ill_vec,
  output logic [N_HYP-1:0]  virt_vec
);
  for (genvar k = 0; k < N_HYP; k++) begin : g_cls
    verdict_t v;
    always_comb begin
      v           = hyp_rule(k, mode, tvm, vtvm, hu);
      ill_vec[k]  = v.ill;
      virt_vec[k] = v.virt;
    end
  end
endmodule

// File: rtl/priv_ext_rules.sv
module priv_ext_rules
  import priv_chk_pkg::*;
#(
  parameter int unsigned FRM_W   = 3,
  parameter int unsigned FRM_MAX = 4,
  parameter int unsigned XS_W    = 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              tw,
  input  logic              vtw,
  input  logic [XS_W-1:0]   fs,
  input  logic [XS_W-1:0]   vs,
  input  logic [FRM_W-1:0]  frm,
  output logic [N_EXT-1:0]  ill_vec,
  output logic [N_EXT-1:0]  virt_vec
);
  localparam logic [FRM_W-1:0] FRM_LIM = FRM_W'(FRM_MAX);
  localparam int unsigned I_FP    = C_FP    - EXT_BASE;
  localparam int unsigned I_FPDYN = C_FPDYN - EXT_BASE;
  localparam int unsigned I_VEC   = C_VEC   - EXT_BASE;
  localparam int unsigned I_WFI   = C_WFI   - EXT_BASE;

  logic     fs_off, vs_off, frm_rsvd;
  verdict_t wv;

  always_comb begin
    fs_off   = (fs == '0);
    vs_off   = (vs == '0);
    frm_rsvd = (frm > FRM_LIM);
    wv       = wfi_rule(mode, tw, vtw);

    ill_vec           = '0;
    virt_vec          = '0;
    ill_vec[I_FP]     = fs_off;
    ill_vec[I_FPDYN]  = fs_off || frm_rsvd;
    ill_vec[I_VEC]    = vs_off;
    ill_vec[I_WFI]    = wv.ill;
    virt_vec[I_WFI]   = wv.virt;
  end
endmodule

// File: rtl/priv_ecall_sel.sv
module priv_ecall_sel
  import priv_chk_pkg::*;
(
  input  logic [MODE_W-1:0]  mode,
  output logic [CAUSE_W-1:0] cause
);
  always_comb cause = ecall_cause(mode);
endmodule

// File: rtl/priv_legality_chk.sv
module priv_legality_chk
  import priv_chk_pkg::*;
#(
  parameter int unsigned FRM_W   = 3,
  parameter int unsigned FRM_MAX = 4,
  parameter int unsigned XS_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [NCLS-1:0]      cls_i,
  input  logic                 tvm_i,
  input  logic                 tw_i,
  input  logic                 vtvm_i,
  input  logic                 vtw_i,
  input  logic                 hu_i,
  input  logic [XS_W-1:0]      fs_i,
  input  logic [XS_W-1:0]      vs_i,
  input  logic [FRM_W-1:0]     frm_i,
  output logic                 illegal_o,
  output logic                 virtual_o,
  output logic                 ecall_o,
  output logic [CAUSE_W-1:0]   ecall_cause_o
);
  logic [N_HYP-1:0]   hyp_ill, hyp_virt;
  logic [N_EXT-1:0]   ext_ill, ext_virt;
  logic [NCLS-1:0]    ill_map, virt_map;
  logic [CAUSE_W-1:0] cause_sel;

  // named internal events
  logic hit_ill, hit_virt, ill_nx, virt_nx, ecall_nx;

  priv_hyp_rules u_hyp (
    .mode     (mode_i),
    .tvm      (tvm_i),
    .vtvm     (vtvm_i),
    .hu       (hu_i),
    .ill_vec  (hyp_ill),
    .virt_vec (hyp_virt)
  );

  priv_ext_rules #(
    .FRM_W   (FRM_W),
    .FRM_MAX (FRM_MAX),
    .XS_W    (XS_W)
  ) u_ext (
    .mode     (mode_i),
    .tw       (tw_i),
    .vtw      (vtw_i),
    .fs       (fs_i),
    .vs       (vs_i),
    .frm      (frm_i),
    .ill_vec  (ext_ill),
    .virt_vec (ext_virt)
  );

  priv_ecall_sel u_ecall (
    .mode  (mode_i),
    .cause (cause_sel)
  );

  always_comb begin
    ill_map  = {1'b0, ext_ill,  hyp_ill};
    virt_map = {1'b0, ext_virt, hyp_virt};
    hit_ill  = |(cls_i & ill_map);
    hit_virt = |(cls_i & virt_map);
    ill_nx   = valid_i && hit_ill;
    virt_nx  = valid_i && hit_virt && !hit_ill;
    ecall_nx = valid_i && cls_i[C_ECALL];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_o     <= 1'b0;
      virtual_o     <= 1'b0;
      ecall_o       <= 1'b0;
      ecall_cause_o <= '0;
    end else begin
      illegal_o     <= ill_nx;
      virtual_o     <= virt_nx;
      ecall_o       <= ecall_nx;
      ecall_cause_o <= ecall_nx ? cause_sel : '0;
    end
  end
endmodule

// File: rtl/priv_legality_chk_sva.sv
module priv_legality_chk_sva
  import priv_chk_pkg::*;
#(
  parameter int unsigned FRM_W   = 3,
  parameter int unsigned FRM_MAX = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                valid_i,
  input logic [MODE_W-1:0]   mode_i,
  input logic [NCLS-1:0]     cls_i,
  input logic [FRM_W-1:0]    frm_i,
  input logic                illegal_o,
  input logic                virtual_o,
  input logic                ecall_o,
  input logic [CAUSE_W-1:0]  ecall_cause_o
);
  localparam logic [NCLS-1:0] UNIT_MASK =
    NCLS'((1 << C_FP) | (1 << C_FPDYN) | (1 << C_VEC));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && virtual_o));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!illegal_o && !virtual_o && !ecall_o));

  assert_m_mode_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == PM_M && (cls_i & UNIT_MASK) == '0)
      |=> (!illegal_o && !virtual_o));

  assert_host_no_virtual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !is_guest(mode_i)) |=> !virtual_o);

  assert_frm_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cls_i[C_FPDYN] && frm_i > FRM_W'(FRM_MAX)) |=> illegal_o);

  assert_mcall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cls_i[C_ECALL] && mode_i == PM_M)
      |=> (ecall_o && ecall_cause_o == CAUSE_M));
endmodule

bind priv_legality_chk priv_legality_chk_sva #(
  .FRM_W   (FRM_W),
  .FRM_MAX (FRM_MAX)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .valid_i       (valid_i),
  .mode_i        (mode_i),
  .cls_i         (cls_i),
  .frm_i         (frm_i),
  .illegal_o     (illegal_o),
  .virtual_o     (virtual_o),
  .ecall_o       (ecall_o),
  .ecall_cause_o (ecall_cause_o)
);

// File: tb/priv_legality_chk_tb.sv
module priv_legality_chk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [9:0] cls_i = '0;
  logic       tvm_i = 0, tw_i = 0, vtvm_i = 0, vtw_i = 0, hu_i = 0;
  logic [1:0] fs_i = 2'd3, vs_i = 2'd3;
  logic [2:0] frm_i = '0;
  logic       illegal_o, virtual_o, ecall_o;
  logic [1:0] ecall_cause_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  priv_legality_chk u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i), .cls_i(cls_i),
    .tvm_i(tvm_i), .tw_i(tw_i), .vtvm_i(vtvm_i), .vtw_i(vtw_i), .hu_i(hu_i),
    .fs_i(fs_i), .vs_i(vs_i), .frm_i(frm_i),
    .illegal_o(illegal_o), .virtual_o(virtual_o), .ecall_o(ecall_o),
    .ecall_cause_o(ecall_cause_o)
  );

  // {ill, virt, ecall, cause[1:0]}, written per mode from the requirements
  function automatic logic [4:0] model(int v, int m, int c, int tvm, int tw, int vtvm,
                                       int vtw, int hu, int fs, int vs, int frm);
    logic il, vi, ec;
    logic [1:0] cz;
    il = 0; vi = 0; ec = 0; cz = 0;
    if (v != 0) begin
      case (c)
        0: begin il = (m == 2) || (m == 1 && tvm != 0); vi = (m == 4) || (m == 3 && vtvm != 0); end
        1: begin il = (m == 2); vi = (m == 4); end
        2: begin il = (m == 2) || (m == 1 && tvm != 0); vi = (m >= 3); end
        3: begin il = (m == 2); vi = (m >= 3); end
        4: begin il = (m == 2) && hu == 0; vi = (m >= 3); end
        5: il = (fs == 0);
        6: il = (fs == 0) || (frm >= 5);
        7: il = (vs == 0);
        8: begin
          if (m == 2) il = 1;
          else if (m != 0 && tw != 0) il = 1;
          if (tw == 0 && m == 4) vi = 1;
          if (tw == 0 && m == 3 && vtw != 0) vi = 1;
        end
        9: begin
          ec = 1;
          cz = (m == 0) ? 2'd3 : (m == 1) ? 2'd1 : (m == 3) ? 2'd2 : 2'd0;
        end
        default: ;
      endcase
      if (il) vi = 0;
    end
    return {il, vi, ec, cz};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {illegal_o, virtual_o, ecall_o, ecall_cause_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // drive at negedge, result registered at the next posedge, sample at the following negedge
  task automatic run(string req, int v, int m, int c, int tvm, int tw, int vtvm, int vtw,
                     int hu, int fs, int vs, int frm, logic [4:0] exp);
    valid_i = (v != 0);
    mode_i  = 3'(m);
    cls_i   = (c >= 0) ? 10'(1 << c) : '0;
    tvm_i = (tvm != 0); tw_i = (tw != 0); vtvm_i = (vtvm != 0);
    vtw_i = (vtw != 0); hu_i = (hu != 0);
    fs_i = 2'(fs); vs_i = 2'(vs); frm_i = 3'(frm);
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic t_reset();
    check("R11 reset state", 5'b0);
    // reset asserted mid-stream with a faulting input
    rst_n = 1'b0;
    run("R11 sync reset clears", 1, 2, 1, 0, 0, 0, 0, 0, 3, 3, 0, 5'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_xlat();
    run("R1 HS tvm=1",  1, 1, 0, 1, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R1 HS tvm=0",  1, 1, 0, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
    run("R1 HU",        1, 2, 0, 0, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R1 VS vtvm=1", 1, 3, 0, 0, 0, 1, 0, 0, 3, 3, 0, 5'b01000);
    run("R1 VS vtvm=0", 1, 3, 0, 1, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
    run("R1 VU",        1, 4, 0, 0, 0, 0, 0, 0, 3, 3, 0, 5'b01000);
    run("R1 M",         1, 0, 0, 1, 1, 1, 1, 0, 3, 3, 0, 5'b00000);
  endtask

  task automatic t_partial();
    run("R2 HU", 1, 2, 1, 0, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R2 VU", 1, 4, 1, 0, 0, 0, 0, 0, 3, 3, 0, 5'b01000);
    run("R2 VS", 1, 3, 1, 1, 1, 1, 1, 0, 3, 3, 0, 5'b00000);
  endtask

  task automatic t_hfence();
    run("R3 gpa HS tvm", 1, 1, 2, 1, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R3 gva HS tvm", 1, 1, 3, 1, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
    run("R3 gva VS",     1, 3, 3, 0, 0, 0, 0, 0, 3, 3, 0, 5'b01000);
    run("R3 gpa VU",     1, 4, 2, 0, 0, 0, 0, 0, 3, 3, 0, 5'b01000);
  endtask

  task automatic t_hls();
    run("R4 HU hu=0", 1, 2, 4, 0, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R4 HU hu=1", 1, 2, 4, 0, 0, 0, 0, 1, 3, 3, 0, 5'b00000);
    run("R4 VS",      1, 3, 4, 0, 0, 0, 0, 1, 3, 3, 0, 5'b01000);
  endtask

  task automatic t_units();
    run("R5 fp off",  1, 0, 5, 0, 0, 0, 0, 0, 0, 3, 0, 5'b10000);
    run("R5 fp on",   1, 3, 5, 0, 0, 0, 0, 0, 1, 0, 0, 5'b00000);
    run("R5 vec off", 1, 4, 7, 0, 0, 0, 0, 0, 3, 0, 0, 5'b10000);
  endtask

  task automatic t_wfi();
    run("R6 HU",         1, 2, 8, 0, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R6 HS tw=1",    1, 1, 8, 0, 1, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R6 M tw=1",     1, 0, 8, 0, 1, 0, 0, 0, 3, 3, 0, 5'b00000);
    run("R10 VU tw=1",   1, 4, 8, 0, 1, 0, 1, 0, 3, 3, 0, 5'b10000);
    run("R7 VU tw=0",    1, 4, 8, 0, 0, 0, 0, 0, 3, 3, 0, 5'b01000);
    run("R7 VS vtw=1",   1, 3, 8, 0, 0, 0, 1, 0, 3, 3, 0, 5'b01000);
    run("R7 VS vtw=0",   1, 3, 8, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
  endtask

  task automatic t_frm();
    run("R8 frm=4", 1, 1, 6, 0, 0, 0, 0, 0, 3, 3, 4, 5'b00000);
    run("R8 frm=5", 1, 1, 6, 0, 0, 0, 0, 0, 3, 3, 5, 5'b10000);
    run("R8 frm=7 plain fp", 1, 1, 5, 0, 0, 0, 0, 0, 3, 3, 7, 5'b00000);
  endtask

  task automatic t_ecall();
    run("R9 M",  1, 0, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00111);
    run("R9 HS", 1, 1, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00101);
    run("R9 HU", 1, 2, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00100);
    run("R9 VS", 1, 3, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00110);
    run("R9 VU", 1, 4, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00100);
  endtask

  task automatic t_idle();
    run("R11 faulting input", 1, 2, 0, 0, 0, 0, 0, 0, 3, 3, 0, 5'b10000);
    run("R11 valid low",      0, 2, 0, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
    run("R11 valid low ecall",0, 0, 9, 0, 0, 0, 0, 0, 3, 3, 0, 5'b00000);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 5; m++)
      for (int c = 0; c < 10; c++)
        for (int b = 0; b < 32; b++)
          for (int u = 0; u < 8; u++) begin
            int fs, vs, frm, v;
            fs  = u[0] ? 3 : 0;
            vs  = u[1] ? 2 : 0;
            frm = u[2] ? 5 : 1;
            v   = ((b + c) % 7 == 6) ? 0 : 1;
            run("R10 sweep", v, m, c, b & 1, (b >> 1) & 1, (b >> 2) & 1, (b >> 3) & 1,
                (b >> 4) & 1, fs, vs, frm,
                model(v, m, c, b & 1, (b >> 1) & 1, (b >> 2) & 1, (b >> 3) & 1,
                      (b >> 4) & 1, fs, vs, frm));
          end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_xlat();
    t_partial();
    t_hfence();
    t_hls();
    t_units();
    t_wfi();
    t_frm();
    t_ecall();
    t_idle();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule